// File: doc/BRIEF.md
# Fan Tachometer Target Register Bank

This block holds the tachometer targets for a five-channel closed-loop fan speed controller. Each fan has a 13-bit target that is split across two byte-wide registers on a simple register bus, which carries an address, a write strobe, write data and combinational read data. A write to a fan's low register only loads a staging register. The fan's active target changes when its high register is written. At that point the new high byte and the staged low bits are committed together, so the control loop never sees a half-updated target.

The committed targets go to the speed-control loop on a flat vector. Each fan has an algorithm-enable input. While a fan is enabled and its committed high byte is saturated at FFh, the block holds that fan's drive-disable level. When an enabled fan's committed high byte leaves FFh, the block emits a one-cycle spin-up request so that the loop restarts the fan before it resumes normal regulation.

Top module: `fan_tgt_regbank`

## Requirements
- R1: After reset every committed target is 1FFFh. Each low register reads F8h, each high register reads FFh, and no spin-up request is active.
- R2: A write to a low register changes neither the committed target nor the read-back value of that register. It only updates the fan's staging register.
- R3: A write to a high register commits the target in the next cycle. The new target is {written byte, most recently staged low bits}.
- R4: Target bits 12..5 map to high-register bits 7..0. Target bits 4..0 map to low-register bits 7..3. Low-register bits 2..0 are ignored on write and read as 0.
- R5: Fan n (n = 0..4) has its low register at byte address 3Ch + 10h·n and its high register at 3Dh + 10h·n. Any other address reads 00h, and a write to it changes no target.
- R6: A fan's drive-disable output is high exactly when its enable input is high and its committed high byte is FFh. It is a level signal, not a pulse.
- R7: When a high-register write moves a fan's committed high byte from FFh to a value other than FFh while that fan's enable is high, the fan's spin-up output is high for exactly the one cycle after the commit.
- R8: No spin-up request is made in three cases: the fan's enable is low at commit, the previous high byte was not FFh, or the new high byte is FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| alg_en_i | input | 5 | Per-fan speed-algorithm enable |
| target_o | output | 65 | Committed targets, fan n at bits [13n+12:13n] |
| drv_off_o | output | 5 | Per-fan drive-disable level |
| spinup_o | output | 5 | Per-fan one-cycle spin-up request |

## Verification
The embedded assertions check the following on every cycle:
- A low write or an idle cycle leaves the committed target untouched.
- A high write commits exactly the written byte and the staged bits.
- A spin-up pulse lasts a single cycle and only follows a departure from FFh.
- A spin-up never coincides with drive-disable.
- At most one register is selected at a time.

The directed scenarios in the bench cover the rest:
- The exact address map.
- The bit placement of the low field and the read-back of committed values.
- The zero reads from unmapped addresses.
- Gating of spin-up by the enable input.
- The return of drive-disable when a target is set back to saturation.

// File: rtl/fan_tgt_pkg.sv
package fan_tgt_pkg;
  localparam int unsigned HI_W   = 8;
  localparam int unsigned LO_W   = 5;
  localparam int unsigned PAD_W  = 3;
  localparam int unsigned BYTE_W = HI_W;

  typedef struct packed {
    logic [HI_W-1:0] hi;
    logic [LO_W-1:0] lo;
  } tgt_t;

  localparam int unsigned TGT_W = $bits(tgt_t);
  localparam logic [HI_W-1:0] HI_SAT = '1;
endpackage

// File: rtl/fan_tgt_addr_dec.sv
module fan_tgt_addr_dec #(
  parameter int unsigned NUM_FANS = 5,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned BASE     = 'h3C,
  parameter int unsigned STRIDE   = 'h10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_i,
  output logic [NUM_FANS-1:0] sel_lo_o,
  output logic [NUM_FANS-1:0] sel_hi_o,
  output logic [NUM_FANS-1:0] wr_lo_o,
  output logic [NUM_FANS-1:0] wr_hi_o
);
  for (genvar g = 0; g < NUM_FANS; g++) begin : g_dec
    localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(BASE + g * STRIDE);
    localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(BASE + g * STRIDE + 1);
    assign sel_lo_o[g] = (addr_i == LO_ADDR);
    assign sel_hi_o[g] = (addr_i == HI_ADDR);
  end

  assign wr_lo_o = sel_lo_o & {NUM_FANS{wr_i}};
  assign wr_hi_o = sel_hi_o & {NUM_FANS{wr_i}};

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sel_lo_o, sel_hi_o})); // R5
endmodule

// File: rtl/fan_tgt_chan.sv
module fan_tgt_chan
  import fan_tgt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              alg_en_i,
  output tgt_t              tgt_o,
  output logic [BYTE_W-1:0] rd_lo_o,
  output logic [BYTE_W-1:0] rd_hi_o,
  output logic              drv_off_o,
  output logic              spinup_o
);
  logic [LO_W-1:0] stage_q;
  tgt_t            tgt_q;
  logic            spin_q;
  logic            leave_sat;

  // staging for the low field; pad bits dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stage_q <= '1;
    else if (wr_lo_i) stage_q <= wdata_i[BYTE_W-1 -: LO_W];
  end

  // atomic commit on high write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tgt_q <= '1;
    else if (wr_hi_i) tgt_q <= '{hi: wdata_i, lo: stage_q};
  end

  assign leave_sat = wr_hi_i && alg_en_i && (tgt_q.hi == HI_SAT) && (wdata_i != HI_SAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) spin_q <= 1'b0;
    else         spin_q <= leave_sat;
  end

  assign tgt_o     = tgt_q;
  assign rd_hi_o   = tgt_q.hi;
  assign rd_lo_o   = {tgt_q.lo, {PAD_W{1'b0}}};
  assign drv_off_o = alg_en_i && (tgt_q.hi == HI_SAT);
  assign spinup_o  = spin_q;

  AST_LO_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> $stable(tgt_q)); // R2
  AST_HI_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> (tgt_q == {$past(wdata_i), $past(stage_q)})); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hi_i |=> $stable(tgt_q)); // R5
  AST_SPIN_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spin_q |=> !spin_q); // R7
  AST_SPIN_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spin_q |-> ($past(tgt_q.hi) == HI_SAT) && (tgt_q.hi != HI_SAT)); // R8
  AST_SPIN_NOT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spin_q |-> !drv_off_o); // R6
endmodule

// File: rtl/fan_tgt_rd_mux.sv
module fan_tgt_rd_mux #(
  parameter int unsigned NUM_FANS = 5,
  parameter int unsigned BYTE_W   = 8
) (
  input  logic [NUM_FANS-1:0]        sel_lo_i,
  input  logic [NUM_FANS-1:0]        sel_hi_i,
  input  logic [NUM_FANS*BYTE_W-1:0] lo_i,
  input  logic [NUM_FANS*BYTE_W-1:0] hi_i,
  output logic [BYTE_W-1:0]          rdata_o
);
  // AND-OR mux; no select gives zero
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_FANS; i++) begin
      rdata_o |= {BYTE_W{sel_lo_i[i]}} & lo_i[i*BYTE_W +: BYTE_W];
      rdata_o |= {BYTE_W{sel_hi_i[i]}} & hi_i[i*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/fan_tgt_regbank.sv
module fan_tgt_regbank
  import fan_tgt_pkg::*;
#(
  parameter int unsigned NUM_FANS = 5,
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned BASE     = 'h3C,
  parameter int unsigned STRIDE   = 'h10
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      wr_i,
  input  logic [BYTE_W-1:0]         wdata_i,
  output logic [BYTE_W-1:0]         rdata_o,
  input  logic [NUM_FANS-1:0]       alg_en_i,
  output logic [NUM_FANS*TGT_W-1:0] target_o,
  output logic [NUM_FANS-1:0]       drv_off_o,
  output logic [NUM_FANS-1:0]       spinup_o
);
  logic [NUM_FANS-1:0]        sel_lo, sel_hi, wr_lo, wr_hi;
  logic [NUM_FANS*BYTE_W-1:0] rd_lo, rd_hi;

  fan_tgt_addr_dec #(
    .NUM_FANS(NUM_FANS), .ADDR_W(ADDR_W), .BASE(BASE), .STRIDE(STRIDE)
  ) u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wr_i     (wr_i),
    .sel_lo_o (sel_lo),
    .sel_hi_o (sel_hi),
    .wr_lo_o  (wr_lo),
    .wr_hi_o  (wr_hi)
  );

  for (genvar g = 0; g < NUM_FANS; g++) begin : g_chan
    tgt_t tgt;
    fan_tgt_chan u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_lo_i   (wr_lo[g]),
      .wr_hi_i   (wr_hi[g]),
      .wdata_i   (wdata_i),
      .alg_en_i  (alg_en_i[g]),
      .tgt_o     (tgt),
      .rd_lo_o   (rd_lo[g*BYTE_W +: BYTE_W]),
      .rd_hi_o   (rd_hi[g*BYTE_W +: BYTE_W]),
      .drv_off_o (drv_off_o[g]),
      .spinup_o  (spinup_o[g])
    );
    assign target_o[g*TGT_W +: TGT_W] = tgt;
  end

  fan_tgt_rd_mux #(.NUM_FANS(NUM_FANS), .BYTE_W(BYTE_W)) u_rd (
    .sel_lo_i (sel_lo),
    .sel_hi_i (sel_hi),
    .lo_i     (rd_lo),
    .hi_i     (rd_hi),
    .rdata_o  (rdata_o)
  );

  AST_SPIN_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(spinup_o)); // R7
endmodule

// File: tb/sim_fan_tgt_regbank.sv
module sim_fan_tgt_regbank;
  localparam int N = 5;
  localparam int TW = 13;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [7:0]    addr_i = '0;
  logic          wr_i = 1'b0;
  logic [7:0]    wdata_i = '0;
  logic [7:0]    rdata_o;
  logic [N-1:0]  alg_en_i = '1;
  logic [N*TW-1:0] target_o;
  logic [N-1:0]  drv_off_o;
  logic [N-1:0]  spinup_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [12:0] exp_tgt [N];
  logic [4:0]  exp_stage [N];

  always #2 clk_i = ~clk_i;  // 250 MHz

  fan_tgt_regbank u0 (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h exp %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] lo_a(int f); return 8'(8'h3C + 16 * f); endfunction
  function automatic logic [7:0] hi_a(int f); return 8'(8'h3D + 16 * f); endfunction

  // model update from the requirements
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
    for (int f = 0; f < N; f++) begin
      if (a == lo_a(f)) exp_stage[f] = d[7:3];
      if (a == hi_a(f)) exp_tgt[f] = {d, exp_stage[f]};
    end
  endtask

  task automatic rd(input logic [7:0] a, input string req, input int exp);
    addr_i = a;
    #1;
    chk(req, $sformatf("read %0h", a), int'(rdata_o), exp);
  endtask

  task automatic chk_tgts(input string req);
    for (int f = 0; f < N; f++)
      chk(req, $sformatf("fan%0d target", f), int'(target_o[f*TW +: TW]), int'(exp_tgt[f]));
  endtask

  task automatic t_reset;
    chk_tgts("R1");
    for (int f = 0; f < N; f++) begin
      rd(lo_a(f), "R1", 'hF8);
      rd(hi_a(f), "R1", 'hFF);
    end
    chk("R1", "spinup", int'(spinup_o), 0);
    chk("R6", "drv_off at reset", int'(drv_off_o), 'h1F);
  endtask

  task automatic t_stage_commit;
    wr(8'h3C, 8'hA7);
    chk_tgts("R2");
    rd(8'h3C, "R2", 'hF8);
    chk("R2", "no spinup on low write", int'(spinup_o), 0);
    wr(8'h3D, 8'h12);
    chk("R3", "fan0 commit", int'(target_o[12:0]), 'h254);
    chk_tgts("R3");
    chk("R7", "spinup pulse", int'(spinup_o), 'h01);
    chk("R6", "drv_off released", int'(drv_off_o[0]), 0);
    @(negedge clk_i);
    chk("R7", "spinup one cycle", int'(spinup_o), 0);
    rd(8'h3C, "R4", 'hA0);
    rd(8'h3D, "R4", 'h12);
  endtask

  task automatic t_no_spin;
    alg_en_i[1] = 1'b0;
    #1;
    chk("R6", "drv_off follows enable", int'(drv_off_o[1]), 0);
    wr(8'h4D, 8'h33);
    chk("R8", "disabled fan no spinup", int'(spinup_o), 0);
    chk_tgts("R3");
    wr(8'h3D, 8'h20);
    chk("R8", "prev not FF no spinup", int'(spinup_o), 0);
    wr(8'h5C, 8'h00);
    wr(8'h5D, 8'hFF);
    chk("R8", "FF to FF no spinup", int'(spinup_o), 0);
    chk("R6", "fan2 still off", int'(drv_off_o[2]), 1);
    rd(8'h5C, "R4", 'h00);
    wr(8'h3D, 8'hFF);
    chk("R6", "fan0 back to off", int'(drv_off_o[0]), 1);
    chk("R8", "to FF no spinup", int'(spinup_o), 0);
  endtask

  task automatic t_map;
    wr(8'h3E, 8'h55);
    wr(8'h40, 8'h00);
    wr(8'h8C, 8'h11);
    wr(8'h2D, 8'h11);
    chk_tgts("R5");
    rd(8'h3E, "R5", 'h00);
    rd(8'h80, "R5", 'h00);
    wr(8'h7C, 8'h0F);
    rd(8'h7C, "R4", 'hF8);
    wr(8'h7D, 8'h01);
    chk("R5", "fan4 target", int'(target_o[4*TW +: TW]), 'h21);
    chk("R7", "fan4 spinup", int'(spinup_o), 'h10);
    rd(8'h7C, "R4", 'h08);
    wr(8'h6D, 8'h80);
    chk("R5", "fan3 target", int'(target_o[3*TW +: TW]), 'h101F);
    chk_tgts("R5");
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got %0d exp 0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < N; f++) begin exp_tgt[f] = '1; exp_stage[f] = '1; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_stage_commit();
    t_no_spin();
    t_map();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule